// File: doc/BRIEF.md
# Tick Timer with Match Modes

This block is a processor system-tick timer. A 32-bit counter advances by one on each tick strobe. The strobe comes from an external 20 MHz timebase, so the counter moves once every 50 ns. A 32-bit control word sets what happens when the low 28 bits of the counter equal a programmed period. The timer can do nothing, restart from zero, stop after one match, or keep running. A match can also latch a sticky pending flag, which drives the interrupt output while interrupts are enabled.

Software reaches the counter and the control word through a single write port, chosen by a select bit. Both registers can be read at all times on dedicated outputs. The interrupt output feeds the exception logic of the processor, which is outside this block.

Top module: `tick_timer`

## Requirements
- R1: While running, the counter adds one on each cycle with `tick_en` high and holds when `tick_en` is low. It wraps from 0xFFFFFFFF to 0.
- R2: Control word layout: bits 31:30 are the mode (00 off, 01 restart, 10 one-shot, 11 continuous), bit 29 is interrupt enable, bit 28 is pending, and bits 27:0 are the period. A match is a tick while running, in a non-off mode, with counter bits 27:0 equal to the period. Counter bits 31:28 play no part in the match.
- R3: A match with interrupt enable set sets the pending bit. `irq_o` is high exactly when pending and enable are both 1.
- R4: In restart mode, a match loads the counter with zero instead of incrementing it.
- R5: In one-shot mode, a match holds the counter and stops all further counting. Counting resumes after a write of a control word whose mode is non-zero.
- R6: In continuous mode, a match lets the counter go on incrementing past the period.
- R7: In off mode, the counter is never altered by a match and pending is never set.
- R8: Reset clears the counter and the control word to zero, and `irq_o` to 0.
- R9: A counter write (`wr_en` high, `wr_sel`=0) loads `wr_data` in place of any increment or restart in the same cycle.
- R10: The pending bit is sticky. Only a control word write (`wr_sel`=1) can change it, and writing 0 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick strobe (20 MHz rate) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the counter, 1 selects the control word |
| wr_data | input | 32 | Write data |
| count_o | output | 32 | Current counter value |
| mode_o | output | 32 | Current control word |
| irq_o | output | 1 | Timer interrupt request |

## Verification
The collision that matters is a software counter write landing on the same tick as a restart-mode match. Two separate paths then try to load the counter in one edge, while the match still tries to latch pending. The bench provokes it by running a restart timer up to its period and issuing a counter write together with the tick that matches. It judges the result by requiring the written value, not zero, on the counter, with pending still set. A control word write that meets a match is treated the same way: the written word wins outright.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    TM_OFF    = 2'b00,
    TM_RELOAD = 2'b01,
    TM_SINGLE = 2'b10,
    TM_FREE   = 2'b11
  } tmode_e;

  // control word fields, counted down from the top bit
  localparam int CTL_HDR_W = 4;   // mode(2) + enable + pending
  localparam int IE_OFS    = 2;   // offset of enable below the top bit
  localparam int PEND_OFS  = 3;   // offset of pending below the top bit
endpackage

// File: rtl/tt_match.sv
module tt_match
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int PER_W = CNT_W - CTL_HDR_W
) (
  input  logic [CNT_W-1:0] count,
  input  logic [PER_W-1:0] period,
  input  tmode_e           mode,
  input  logic             running,
  input  logic             tick_en,
  output logic             hit
);
  function automatic logic field_eq(input logic [CNT_W-1:0] c,
                                    input logic [PER_W-1:0] p);
    return c[PER_W-1:0] == p;
  endfunction

  always_comb hit = tick_en && running && (mode != TM_OFF) && field_eq(count, period);
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             running,
  input  logic             hit,
  input  tmode_e           mode,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic h,
                                                  input tmode_e m,
                                                  input logic adv);
    if (h && m == TM_RELOAD) return '0;
    if (h && m == TM_SINGLE) return c;
    if (adv)                 return c + CNT_W'(1);
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (cnt_wr) count <= wr_data;
    else             count <= next_count(count, hit, mode, tick_en && running);
  end
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             mode_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] ctl,
  output logic             running
);
  localparam int IE_B   = CNT_W - 1 - IE_OFS;
  localparam int PEND_B = CNT_W - 1 - PEND_OFS;

  tmode_e cur_mode, new_mode;
  always_comb cur_mode = tmode_e'(ctl[CNT_W-1 -: 2]);
  always_comb new_mode = tmode_e'(wr_data[CNT_W-1 -: 2]);

  always_ff @(posedge clk) begin
    if (!rst_n)                ctl <= '0;
    else if (mode_wr)          ctl <= wr_data;
    else if (hit && ctl[IE_B]) ctl[PEND_B] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                running <= 1'b1;
    else if (mode_wr && new_mode != TM_OFF)    running <= 1'b1;
    else if (hit && cur_mode == TM_SINGLE)     running <= 1'b0;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int PER_W = CNT_W - CTL_HDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] mode_o,
  output logic             irq_o
);
  // named internal events, observed by the checker
  logic   hit_w, cnt_wr_w, mode_wr_w, run_w;
  tmode_e mode_w;

  assign cnt_wr_w  = wr_en && !wr_sel;
  assign mode_wr_w = wr_en && wr_sel;
  assign mode_w    = tmode_e'(mode_o[CNT_W-1 -: 2]);

  tt_match #(.CNT_W(CNT_W)) u_match (
    .count(count_o), .period(mode_o[PER_W-1:0]), .mode(mode_w),
    .running(run_w), .tick_en(tick_en), .hit(hit_w)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .running(run_w),
    .hit(hit_w), .mode(mode_w), .cnt_wr(cnt_wr_w), .wr_data(wr_data),
    .count(count_o)
  );

  tt_ctrl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .mode_wr(mode_wr_w),
    .wr_data(wr_data), .ctl(mode_o), .running(run_w)
  );

  assign irq_o = mode_o[CNT_W-1-IE_OFS] && mode_o[CNT_W-1-PEND_OFS];
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] mode_o,
  input logic             irq_o,
  input logic             hit_w,
  input logic             cnt_wr_w,
  input logic             mode_wr_w,
  input logic             run_w
);
  localparam int IE_B   = CNT_W - 3;
  localparam int PEND_B = CNT_W - 4;

  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && run_w && !hit_w && !cnt_wr_w |=> count_o == $past(count_o) + CNT_W'(1));

  p_match_pends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w && mode_o[IE_B] && !mode_wr_w |=> mode_o[PEND_B] && irq_o);

  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w && mode_o[CNT_W-1 -: 2] == 2'b01 && !cnt_wr_w |=> count_o == '0);

  p_stopped_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w && !cnt_wr_w |=> $stable(count_o));

  p_cont_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w && mode_o[CNT_W-1 -: 2] == 2'b11 && !cnt_wr_w |=> count_o == $past(count_o) + CNT_W'(1));

  p_off_no_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[CNT_W-1 -: 2] == 2'b00 && !mode_o[PEND_B] && !mode_wr_w |=> !mode_o[PEND_B]);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_w |=> count_o == $past(wr_data));

  p_pend_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[PEND_B] && !mode_wr_w |=> mode_o[PEND_B]);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_data(wr_data),
  .count_o(count_o), .mode_o(mode_o), .irq_o(irq_o), .hit_w(hit_w),
  .cnt_wr_w(cnt_wr_w), .mode_wr_w(mode_wr_w), .run_w(run_w)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_o, mode_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state, built from the requirements
  logic [31:0] m_cnt = '0, m_ctl = '0;
  bit          m_run = 1;

  logic [31:0] qc[$], qm[$];
  logic        qi[$];
  string       qt[$];

  always #2.5 clk = ~clk;

  tick_timer u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
                 .wr_sel(wr_sel), .wr_data(wr_data), .count_o(count_o),
                 .mode_o(mode_o), .irq_o(irq_o));

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input logic tk, input logic we, input logic sel,
                      input logic [31:0] d, input string tag);
    logic [1:0] md;
    bit hit;
    logic [31:0] nc, nm;
    bit nr;
    @(negedge clk);
    tick_en = tk; wr_en = we; wr_sel = sel; wr_data = d;
    md  = m_ctl[31:30];
    hit = tk && m_run && md != 2'b00 && (m_cnt[27:0] == m_ctl[27:0]);
    nc = m_cnt;
    if (we && !sel)              nc = d;
    else if (hit && md == 2'b01) nc = 32'h0;
    else if (hit && md == 2'b10) nc = m_cnt;
    else if (tk && m_run)        nc = m_cnt + 32'h1;
    nm = m_ctl;
    if (we && sel)               nm = d;
    else if (hit && m_ctl[29])   nm[28] = 1'b1;
    nr = m_run;
    if (we && sel && d[31:30] != 2'b00) nr = 1;
    else if (hit && md == 2'b10)        nr = 0;
    m_cnt = nc; m_ctl = nm; m_run = nr;
    qc.push_back(nc); qm.push_back(nm); qi.push_back(nm[28] & nm[29]); qt.push_back(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b1, 1'b0, 1'b0, 32'h0, tag);
  endtask
  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 32'h0, tag);
  endtask
  task automatic wcnt(input logic [31:0] d, input string tag);
    step(1'b0, 1'b1, 1'b0, d, tag);
  endtask
  task automatic wctl(input logic [31:0] d, input string tag);
    step(1'b0, 1'b1, 1'b1, d, tag);
  endtask

  // monitor: compares each result one step after its edge
  always @(posedge clk) begin
    #1;
    if (qc.size() > 0) begin
      string t;
      logic [31:0] ec, em;
      logic ei;
      t = qt.pop_front(); ec = qc.pop_front(); em = qm.pop_front(); ei = qi.pop_front();
      chk(t, "count", count_o, ec);
      chk(t, "ctl", mode_o, em);
      chk(t, "irq", {31'h0, irq_o}, {31'h0, ei});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "reset count", count_o, 32'h0);
    chk("R8", "reset ctl", mode_o, 32'h0);
    chk("R8", "reset irq", {31'h0, irq_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    ticks(5, "R1");
    idle(3, "R1 hold");
    wcnt(32'hFFFF_FFFE, "R9 load");
    ticks(3, "R1 wrap");

    wcnt(32'h0, "R7 setup");
    wctl(32'h2000_0003, "R7 setup");
    ticks(8, "R7");

    wctl(32'h6000_0003, "R4 setup");
    wcnt(32'h0, "R4 setup");
    ticks(10, "R4");
    idle(2, "R10 sticky");
    wctl(32'h4000_0003, "R10 clear");
    ticks(6, "R10 no enable");

    wcnt(32'h0, "R9 setup");
    wctl(32'h6000_0003, "R9 setup");
    ticks(3, "R9 setup");
    step(1'b1, 1'b1, 1'b0, 32'h0000_0010, "R9 collide");
    step(1'b1, 1'b1, 1'b0, 32'h0000_0007, "R9 tick");
    wcnt(32'h0000_0003, "R9 setup");
    step(1'b1, 1'b1, 1'b1, 32'h4000_0009, "R10 ctl write wins");

    wcnt(32'h0, "R5 setup");
    wctl(32'hA000_0002, "R5 setup");
    ticks(6, "R5");
    wcnt(32'h0, "R5 stopped write");
    ticks(3, "R5 stays stopped");
    wctl(32'hA000_0004, "R5 resume");
    ticks(7, "R5 second shot");

    wcnt(32'h0, "R6 setup");
    wctl(32'hE000_0002, "R6 setup");
    ticks(6, "R6");

    wctl(32'h6000_0002, "R2 setup");
    wcnt(32'hF000_0001, "R2 setup");
    ticks(4, "R2 high bits ignored");

    idle(2, "end");
    while (qc.size() > 0) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule